// File: doc/BRIEF.md
# Serial Offset Min-Sum Check Node Unit

This block handles one check node of a layered LDPC decoder. It takes one variable-to-check message per clock, as a 5-bit two's-complement value, over the edges of the check node. While the messages arrive it keeps a compact running summary: the smallest magnitude seen so far, the second smallest, the edge position of the smallest, and the parity of all message signs. After the last edge it subtracts a programmable offset from the two magnitudes, clamps each at zero, and presents the result as a held final state.

Two pipeline stages do the work. The running summary is one stage and the corrected result is the other. Because the stages are separate, the next check node can begin streaming on the clock right after the previous node's last edge, while the earlier result is still being formed and then held. Edges that belong to null blocks of the parity-check matrix are flagged. Such an edge is treated as a positive value of the largest magnitude, so it cannot change either minimum or the sign.

Top module: `ms_check_unit`

## Requirements
- R1: After reset, `fs_valid` and `fs_done` are 0, `fs_min1`, `fs_min2`, `fs_idx` and `fs_sign` are 0, and the offset register holds 0.
- R2: Each input is converted from two's complement to sign and magnitude. The sign is bit 4 and the magnitude is the absolute value. Input 5'b10000 (-16) saturates to magnitude 15.
- R3: The final state reports the smallest magnitude of the node in `fs_min1` and the second smallest in `fs_min2`, counting every edge of the node. Both are offset-corrected.
- R4: `fs_idx` is the edge position of the smallest magnitude. The edge carrying `start` is position 0. When a later edge equals the current smallest magnitude, that later edge becomes the second minimum and the index keeps the earlier position.
- R5: `fs_sign` is the XOR of the sign bits of all edges of the node that are not null.
- R6: Each corrected magnitude equals max(m - beta, 0). Beta is the 4-bit offset register, loaded from `beta_din` on a clock where `beta_wr` is 1. The correction uses the offset held when the final state is formed.
- R7: When the edge with `in_last` is taken at clock edge t, `fs_done` is 1 for exactly one cycle after edge t+1. At that same point the new final state appears and `fs_valid` is 1. The final state is then held unchanged until the next node completes.
- R8: A new node may begin (`start` together with `in_valid`) on the clock right after the previous node's last edge. The previous node's result is unaffected by this.
- R9: An edge with `in_null` set is treated as magnitude 15 with a positive sign. It still occupies an edge position.
- R10: A cycle with `in_valid` low changes neither the running summary nor the edge position, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beta_wr | input | 1 | Load the offset register |
| beta_din | input | 4 | New offset value |
| in_valid | input | 1 | An edge message is present this cycle |
| start | input | 1 | This edge is the first of a new check node |
| in_last | input | 1 | This edge is the last of the check node |
| in_null | input | 1 | This edge belongs to a null block |
| in_msg | input | 5 | Variable-to-check message, two's complement |
| fs_done | output | 1 | One-cycle pulse: a new final state is present |
| fs_valid | output | 1 | A final state has been produced since reset |
| fs_min1 | output | 4 | Offset-corrected smallest magnitude |
| fs_min2 | output | 4 | Offset-corrected second smallest magnitude |
| fs_idx | output | 5 | Edge position of the smallest magnitude |
| fs_sign | output | 1 | Sign parity of the node's edges |

## Verification
On every cycle, the in-line properties check four things. The running minimum never exceeds the running second minimum. The done pulse follows a last edge by exactly two clocks. The final state stays still when no node has just completed. A null edge leaves the running sign and minimum alone. The actual values need the directed scenarios to show them: the saturation of -16, the tie-breaking on the index, offset clamping at zero, sign parity, skipped idle cycles, and back-to-back nodes whose results stay separate. Each scenario compares the outputs with values the bench derives itself from its list of input messages.

// File: rtl/ms_check_unit.sv
module ms_check_unit #(
  parameter int MSG_W   = 5,
  parameter int DEG_MAX = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         beta_wr,
  input  logic [MSG_W-2:0]             beta_din,
  input  logic                         in_valid,
  input  logic                         start,
  input  logic                         in_last,
  input  logic                         in_null,
  input  logic [MSG_W-1:0]             in_msg,
  output logic                         fs_done,
  output logic                         fs_valid,
  output logic [MSG_W-2:0]             fs_min1,
  output logic [MSG_W-2:0]             fs_min2,
  output logic [$clog2(DEG_MAX)-1:0]   fs_idx,
  output logic                         fs_sign
);
  localparam int MAG_W = MSG_W - 1;
  localparam int IDX_W = $clog2(DEG_MAX);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEG_MAX - 1);

  logic [MAG_W-1:0] beta_q;
  logic [MAG_W-1:0] ps_m1, ps_m2;
  logic [IDX_W-1:0] ps_idx, ps_cnt;
  logic             ps_sign, last_q;

  // two's complement to sign-magnitude, -2^(W-1) saturates
  wire             raw_sgn  = in_msg[MSG_W-1];
  wire [MSG_W-1:0] raw_abs  = raw_sgn ? (~in_msg + 1'b1) : in_msg;
  wire [MAG_W-1:0] raw_mag  = raw_abs[MSG_W-1] ? MAG_MAX : raw_abs[MAG_W-1:0];
  wire [MAG_W-1:0] eff_mag  = in_null ? MAG_MAX : raw_mag;
  wire             eff_sgn  = in_null ? 1'b0 : raw_sgn;

  wire [MAG_W-1:0] b_m1   = start ? MAG_MAX : ps_m1;
  wire [MAG_W-1:0] b_m2   = start ? MAG_MAX : ps_m2;
  wire [IDX_W-1:0] b_idx  = start ? '0 : ps_idx;
  wire             b_sign = start ? 1'b0 : ps_sign;
  wire [IDX_W-1:0] pos    = start ? '0 : ps_cnt;

  wire lt_m1 = eff_mag < b_m1;
  wire lt_m2 = eff_mag < b_m2;

  wire [MAG_W-1:0] cor_m1 = (ps_m1 > beta_q) ? ps_m1 - beta_q : '0;
  wire [MAG_W-1:0] cor_m2 = (ps_m2 > beta_q) ? ps_m2 - beta_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beta_q <= '0;
    else if (beta_wr) beta_q <= beta_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_m1   <= MAG_MAX;
      ps_m2   <= MAG_MAX;
      ps_idx  <= '0;
      ps_cnt  <= '0;
      ps_sign <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      last_q <= in_valid && in_last;
      if (in_valid) begin
        ps_sign <= b_sign ^ eff_sgn;
        ps_cnt  <= (pos == IDX_TOP) ? IDX_TOP : pos + 1'b1;
        if (lt_m1) begin
          ps_m1  <= eff_mag;
          ps_m2  <= b_m1;
          ps_idx <= pos;
        end else begin
          ps_m1  <= b_m1;
          ps_m2  <= lt_m2 ? eff_mag : b_m2;
          ps_idx <= b_idx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_done  <= 1'b0;
      fs_valid <= 1'b0;
      fs_min1  <= '0;
      fs_min2  <= '0;
      fs_idx   <= '0;
      fs_sign  <= 1'b0;
    end else begin
      fs_done <= last_q;
      if (last_q) begin
        fs_valid <= 1'b1;
        fs_min1  <= cor_m1;
        fs_min2  <= cor_m2;
        fs_idx   <= ps_idx;
        fs_sign  <= ps_sign;
      end
    end
  end

  assert_ps_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ps_m1 <= ps_m2);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> ##1 (fs_done && fs_valid));

  assert_fs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> ##1 ($stable(fs_min1) && $stable(fs_min2) &&
                                    $stable(fs_idx) && $stable(fs_sign) && !fs_done));

  assert_null_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_null && !start) |=> ($stable(ps_sign) && $stable(ps_m1) && $stable(ps_idx)));

endmodule

// File: tb/ms_check_unit_bench.sv
module ms_check_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beta_wr = 1'b0;
  logic [3:0] beta_din = '0;
  logic       in_valid = 1'b0, start = 1'b0, in_last = 1'b0, in_null = 1'b0;
  logic [4:0] in_msg = '0;
  logic       fs_done, fs_valid, fs_sign;
  logic [3:0] fs_min1, fs_min2;
  logic [4:0] fs_idx;

  int n_checks = 0;
  int n_fail = 0;

  logic [4:0] q_val [32];
  bit         q_nul [32];
  int         q_len;
  int         beta_cur = 0;
  int         e_m1, e_m2, e_idx, e_sgn;

  always #2 clk = ~clk;

  ms_check_unit u_ms_check_unit (
    .clk(clk), .rst_n(rst_n), .beta_wr(beta_wr), .beta_din(beta_din),
    .in_valid(in_valid), .start(start), .in_last(in_last), .in_null(in_null),
    .in_msg(in_msg), .fs_done(fs_done), .fs_valid(fs_valid),
    .fs_min1(fs_min1), .fs_min2(fs_min2), .fs_idx(fs_idx), .fs_sign(fs_sign)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mag_of(int i);
    logic [4:0] v;
    int a;
    if (q_nul[i]) return 15;
    v = q_val[i];
    a = v[4] ? (32 - int'(v)) : int'(v);
    return (a > 15) ? 15 : a;
  endfunction

  task automatic compute_expect();
    int m1, m2;
    m1 = 15; e_idx = 0; e_sgn = 0;
    for (int i = 0; i < q_len; i++) if (mag_of(i) < m1) m1 = mag_of(i);
    for (int i = q_len - 1; i >= 0; i--) if (mag_of(i) == m1) e_idx = i;
    m2 = 15;
    for (int i = 0; i < q_len; i++) if (i != e_idx && mag_of(i) < m2) m2 = mag_of(i);
    for (int i = 0; i < q_len; i++) if (!q_nul[i]) e_sgn ^= int'(q_val[i][4]);
    e_m1 = (m1 > beta_cur) ? m1 - beta_cur : 0;
    e_m2 = (m2 > beta_cur) ? m2 - beta_cur : 0;
  endtask

  task automatic drive_edge(int i);
    in_valid = 1'b1;
    start    = (i == 0);
    in_last  = (i == q_len - 1);
    in_null  = q_nul[i];
    in_msg   = q_val[i];
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; start = 1'b0; in_last = 1'b0; in_null = 1'b0;
  endtask

  task automatic check_result(string req, int m1, int m2, int idx, int sg);
    chk({req, " done"}, int'(fs_done), 1);
    chk({req, " valid"}, int'(fs_valid), 1);
    chk({req, " min1"}, int'(fs_min1), m1);
    chk({req, " min2"}, int'(fs_min2), m2);
    chk({req, " idx"}, int'(fs_idx), idx);
    chk({req, " sign"}, int'(fs_sign), sg);
  endtask

  task automatic run_node(string req);
    compute_expect();
    for (int i = 0; i < q_len; i++) begin
      @(negedge clk); drive_edge(i);
    end
    @(negedge clk); idle_inputs(); in_msg = 5'b10101;
    chk({req, " no early done"}, int'(fs_done), 0);
    @(negedge clk);
    check_result(req, e_m1, e_m2, e_idx, e_sgn);
  endtask

  task automatic set_beta(int b);
    @(negedge clk); beta_wr = 1'b1; beta_din = 4'(b);
    @(negedge clk); beta_wr = 1'b0; beta_cur = b;
  endtask

  task automatic fill(int n);
    q_len = n;
    for (int i = 0; i < 32; i++) q_nul[i] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 done", int'(fs_done), 0);
    chk("R1 valid", int'(fs_valid), 0);
    chk("R1 min1", int'(fs_min1), 0);
    chk("R1 min2", int'(fs_min2), 0);
    chk("R1 idx", int'(fs_idx), 0);
    chk("R1 sign", int'(fs_sign), 0);
  endtask

  task automatic t_basic();
    fill(6);
    q_val[0] = 5'd9;  q_val[1] = 5'b11010; q_val[2] = 5'd12;
    q_val[3] = 5'b11111; q_val[4] = 5'd4;  q_val[5] = 5'b11000;
    run_node("R3 R4 R5 basic");
  endtask

  task automatic t_beta_reset();
    fill(3);
    q_val[0] = 5'd7; q_val[1] = 5'd2; q_val[2] = 5'd5;
    compute_expect();
    run_node("R6 reset beta");
    chk("R6 zero offset min1", int'(fs_min1), 2);
  endtask

  task automatic t_saturate();
    fill(3);
    q_val[0] = 5'b10000; q_val[1] = 5'b10000; q_val[2] = 5'b10001;
    run_node("R2 saturate");
    chk("R2 sat min2", int'(fs_min2), 15);
  endtask

  task automatic t_tie();
    fill(5);
    q_val[0] = 5'd8; q_val[1] = 5'd3; q_val[2] = 5'b11101;
    q_val[3] = 5'd6; q_val[4] = 5'd3;
    run_node("R4 tie");
    chk("R4 tie idx", int'(fs_idx), 1);
    chk("R4 tie min2", int'(fs_min2), 3);
  endtask

  task automatic t_offset();
    set_beta(3);
    fill(4);
    q_val[0] = 5'd2; q_val[1] = 5'b11011; q_val[2] = 5'd10; q_val[3] = 5'd11;
    run_node("R6 offset clamp");
    chk("R6 clamp min1", int'(fs_min1), 0);
    fill(3);
    q_val[0] = 5'd13; q_val[1] = 5'd9; q_val[2] = 5'b10110;
    run_node("R6 offset sub");
    chk("R6 sub min1", int'(fs_min1), 6);
    set_beta(0);
  endtask

  task automatic t_null();
    fill(6);
    q_val[0] = 5'b11100; q_nul[0] = 1'b1;
    q_val[1] = 5'b11110; q_nul[1] = 1'b1;
    q_val[2] = 5'd6;
    q_val[3] = 5'b00001; q_nul[3] = 1'b1;
    q_val[4] = 5'b11001;
    q_val[5] = 5'd0; q_nul[5] = 1'b1;
    run_node("R9 null");
    chk("R9 null idx", int'(fs_idx), 2);
    chk("R9 null sign", int'(fs_sign), 1);
  endtask

  task automatic t_gaps();
    fill(4);
    q_val[0] = 5'd11; q_val[1] = 5'd7; q_val[2] = 5'b11110; q_val[3] = 5'd9;
    compute_expect();
    for (int i = 0; i < q_len; i++) begin
      @(negedge clk); drive_edge(i);
      if (i < q_len - 1) begin
        @(negedge clk);
        in_valid = 1'b0; start = 1'b1; in_last = 1'b1; in_null = 1'b0; in_msg = 5'b10000;
      end
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);
    check_result("R10 gaps", e_m1, e_m2, e_idx, e_sgn);
  endtask

  task automatic t_pipeline();
    int a1, a2, ai, as_;
    fill(3);
    q_val[0] = 5'd5; q_val[1] = 5'b11110; q_val[2] = 5'd9;
    compute_expect();
    a1 = e_m1; a2 = e_m2; ai = e_idx; as_ = e_sgn;
    for (int i = 0; i < q_len; i++) begin
      @(negedge clk); drive_edge(i);
    end
    fill(4);
    q_val[0] = 5'd14; q_val[1] = 5'd12; q_val[2] = 5'b11101; q_val[3] = 5'd1;
    compute_expect();
    for (int i = 0; i < q_len; i++) begin
      @(negedge clk);
      if (i == 1) check_result("R8 first node", a1, a2, ai, as_);
      if (i == 2) begin
        chk("R7 done single pulse", int'(fs_done), 0);
        chk("R7 held min1", int'(fs_min1), a1);
      end
      drive_edge(i);
    end
    @(negedge clk); idle_inputs();
    chk("R7 held idx", int'(fs_idx), ai);
    @(negedge clk);
    check_result("R8 second node", e_m1, e_m2, e_idx, e_sgn);
    repeat (3) @(negedge clk);
    chk("R7 hold done low", int'(fs_done), 0);
    chk("R7 hold min2", int'(fs_min2), e_m2);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_beta_reset();
    t_basic();
    t_saturate();
    t_tie();
    t_offset();
    t_null();
    t_gaps();
    t_pipeline();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule